// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block behaves as a small byte-addressed non-volatile memory reached over a two-wire I2C bus. A master opens a transfer with a start condition and a control byte carrying a fixed device code, block-select bits and a direction bit. In the write direction the master then sends an 8-bit word address and, optionally, one data byte; the byte is committed when the master issues a stop. In the read direction the block returns bytes from a single internal address pointer. That pointer serves three kinds of read: a current-address read, a random read (address phase followed by a repeated start) and a sequential read that continues while the master acknowledges.

After a committed write the block runs a self-timed write cycle of a fixed number of clocks. During that cycle it refuses to acknowledge its control byte, so a master can poll for completion. A write-protect input and a low-supply inhibit input each keep the array unchanged. The bus lines arrive as oversampled levels and are synchronised inside the block. SDA is driven through an open-drain enable that is only changed while SCL is low. The array is 512 bytes by default, or 1024 bytes through a parameter.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: Only a control byte whose upper four bits equal the device code (default 4'b1010) is acknowledged. With any other code the slave leaves SDA released until the next start or stop.
- R2: Control byte bit 0 selects the direction (1 = read, 0 = write). Bits [N:1], where N is the number of address bits above eight (bit 1 only for 512 bytes), supply the upper address bits above the word address byte of a write command.
- R3: A byte write (control, word address, one data byte, all acknowledged) takes effect at the stop condition. A second data byte in the same transfer is not acknowledged and is discarded.
- R4: A current-address read returns the byte that follows the last byte read or written.
- R5: A random read loads the pointer from the word address. The repeated start ends the write phase without writing memory.
- R6: While the master acknowledges each data byte, the slave sends the bytes at successive addresses. The pointer wraps from the last address to address 0.
- R7: After a committed write the slave does not acknowledge any control byte for WRITE_CYCLES clocks counted from the stop. Afterwards it acknowledges again.
- R8: With the write-protect input high at the stop, a write is still fully acknowledged but memory is unchanged and no busy period follows.
- R9: With the low-supply inhibit input high at the stop, memory is unchanged and no busy period follows.
- R10: The SDA drive enable changes only while the synchronised SCL is low.
- R11: After reset SDA is released, the slave is idle and it is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wp_i | input | 1 | Write protect, high makes the array read-only |
| lowv_i | input | 1 | Low-supply inhibit, high blocks any write |

## Verification
Table-driven byte writes go to pairs of addresses that differ only in the block-select bit, and also to the first and last locations. Each is followed by a random read-back, which separates a correct address concatenation from block aliasing. Acknowledge polling right after each stop, timed against the write-cycle length, tells a missing busy period from an over-long one. Directed transfers cover the remaining mechanisms: current-address reads after a random read, a sequential read across the wrap point, a second data byte, protected and inhibited writes, and a foreign device code. Each transfer shows at the bus whether the pointer, the commit or the acknowledge logic was at fault.

// File: rtl/eeprom_i2c_pkg.sv
`timescale 1ns/1ps
package eeprom_i2c_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CTRL, S_CTRL_ACK, S_WADDR, S_WADDR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RACK, S_RNEXT, S_IGNORE
  } slv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
// Synchronises the two bus lines and derives edge and bus-condition events.
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_sh[SYNC_STAGES-1];
      sda_q  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_sh[SYNC_STAGES-1];
  assign sda_s    = sda_sh[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // SDA moving while SCL stays high marks start (falling) or stop (rising)
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_byte_ram.sv
`timescale 1ns/1ps
// Simple dual-port byte array with registered read, suited to block RAM.
module eeprom_byte_ram #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_i2c_slave.sv
`timescale 1ns/1ps
module eeprom_i2c_slave
  import eeprom_i2c_pkg::*;
#(
  parameter int         MEM_BYTES    = 512,
  parameter int         WRITE_CYCLES = 1000,
  parameter logic [3:0] DEV_CODE     = 4'b1010,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic wp_i,
  input  logic lowv_i
);
  localparam int AW     = $clog2(MEM_BYTES);
  localparam int BLK_W  = AW - 8;
  localparam int BUSY_W = $clog2(WRITE_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  slv_state_t           state;
  logic [7:0]           shreg;
  logic [3:0]           bitcnt;
  logic [AW-1:0]        ptr, wr_addr;
  logic [7:0]           wr_data, mem_rdata;
  logic                 pend, rw;
  logic [BLK_W-1:0]     blk;
  logic [BUSY_W-1:0]    busy_cnt;
  logic                 busy, mem_we;

  assign busy   = (busy_cnt != '0);
  // commit only at stop, and only when neither protect nor inhibit is active
  assign mem_we = stop_ev & pend & ~wp_i & ~lowv_i;

  eeprom_byte_ram #(.DEPTH(MEM_BYTES)) u_ram (
    .clk(clk), .we(mem_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst)          busy_cnt <= '0;
    else if (mem_we)  busy_cnt <= BUSY_W'(WRITE_CYCLES);
    else if (busy)    busy_cnt <= busy_cnt - BUSY_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      sda_oe  <= 1'b0;
      shreg   <= '0;
      bitcnt  <= '0;
      ptr     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      pend    <= 1'b0;
      rw      <= 1'b0;
      blk     <= '0;
    end else if (start_ev) begin
      state  <= S_CTRL;
      bitcnt <= '0;
      sda_oe <= 1'b0;
      pend   <= 1'b0;   // repeated start abandons an uncommitted byte
    end else if (stop_ev) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
      pend   <= 1'b0;
    end else begin
      case (state)
        S_CTRL, S_WADDR, S_WDATA: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (state == S_CTRL) begin
              if (shreg[7:4] == DEV_CODE && !busy) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                if (!shreg[0]) blk <= shreg[BLK_W:1];
                state  <= S_CTRL_ACK;
              end else begin
                state <= S_IGNORE;
              end
            end else if (state == S_WADDR) begin
              sda_oe <= 1'b1;
              ptr    <= {blk, shreg};
              state  <= S_WADDR_ACK;
            end else if (!pend) begin
              sda_oe  <= 1'b1;
              pend    <= 1'b1;
              wr_addr <= ptr;
              wr_data <= shreg;
              ptr     <= ptr + AW'(1);
              state   <= S_WDATA_ACK;
            end else begin
              state <= S_IGNORE;   // only one byte per write transfer
            end
          end
        end
        S_CTRL_ACK, S_WADDR_ACK, S_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            if (state == S_CTRL_ACK && rw) begin
              shreg  <= mem_rdata;
              sda_oe <= ~mem_rdata[7];
              bitcnt <= 4'd1;
              state  <= S_RDATA;
            end else if (state == S_CTRL_ACK) begin
              state <= S_WADDR;
            end else begin
              state <= S_WDATA;
            end
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            if (bitcnt != 4'd8) begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end else begin
              sda_oe <= 1'b0;
              ptr    <= ptr + AW'(1);
              state  <= S_RACK;
            end
          end
        end
        S_RACK: begin
          if (scl_rise) state <= sda_s ? S_IGNORE : S_RNEXT;
        end
        S_RNEXT: begin
          if (scl_fall) begin
            shreg  <= mem_rdata;
            sda_oe <= ~mem_rdata[7];
            bitcnt <= 4'd1;
            state  <= S_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: the drive enable only moves while the clock line is low
  a_r10_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  // R1: a rejected transfer keeps SDA released
  a_r1_ignore_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_IGNORE) |-> !sda_oe);
  // R7: no new commit can be issued while a write cycle is running
  a_r7_no_write_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !busy);
  // R7: a commit opens a full-length busy window
  a_r7_busy_window: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (busy_cnt == BUSY_W'(WRITE_CYCLES)));
  // R6: each transmitted byte advances the pointer by exactly one
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_RDATA && state == S_RACK) |-> (ptr == $past(ptr) + AW'(1)));
  // R2: the low pointer byte is the received word address
  a_r2_addr_load: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_WADDR && state == S_WADDR_ACK) |-> (ptr[7:0] == $past(shreg)));
  // R11: leaving reset, the slave is idle, quiet and not busy
  a_r11_reset_state: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (!sda_oe && !busy && state == S_IDLE));
endmodule

// File: tb/eeprom_i2c_slave_tb.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_tb;
  localparam int WCYC = 1000;
  localparam int HP   = 80;   // SCL high/low phase in ns
  localparam int Q    = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wp = 1'b0, lowv = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int total = 0, fails = 0, oe_viol = 0;
  logic oe_prev = 1'b0;

  assign sda_bus = m_sda & ~sda_oe;
  always #2.5 clk = ~clk;

  eeprom_i2c_slave #(.MEM_BYTES(512), .WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .wp_i(wp), .lowv_i(lowv)
  );

  // R10 bus monitor: the enable must not move while SCL is high
  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_prev && m_scl) oe_viol++;
    oe_prev = sda_oe;
  end

  // stimulus table: {address, data}
  localparam logic [16:0] VEC [6] = '{
    {9'h010, 8'h11}, {9'h011, 8'h22}, {9'h1FF, 8'hA5},
    {9'h000, 8'h5A}, {9'h001, 8'h3C}, {9'h110, 8'hC3}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #HP; m_sda = 1'b0; #HP; m_scl = 1'b0; #Q;
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #HP; m_sda = 1'b1; #HP;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; #Q; m_scl = 1'b1; #HP; m_scl = 1'b0; #Q;
    end
    m_sda = 1'b1; #Q; m_scl = 1'b1; #(HP/2);
    ack = (sda_bus == 1'b0);
    #(HP/2); m_scl = 1'b0; #Q;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic m_ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; #Q; m_scl = 1'b1; #(HP/2);
      b[i] = sda_bus;
      #(HP/2); m_scl = 1'b0; #Q;
    end
    m_sda = m_ack ? 1'b0 : 1'b1; #Q; m_scl = 1'b1; #HP; m_scl = 1'b0; #Q;
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] ctrl(input logic [8:0] a, input logic rd);
    return {4'b1010, 2'b00, a[8], rd};
  endfunction

  task automatic write_byte(input logic [8:0] a, input logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    i2c_start();
    send_byte(ctrl(a, 1'b0), k1);
    send_byte(a[7:0], k2);
    send_byte(d, k3);
    i2c_stop();
    ok = k1 & k2 & k3;
  endtask

  task automatic poll_ready(output int n);
    logic k;
    n = 0;
    do begin
      i2c_start();
      send_byte(8'hA0, k);
      i2c_stop();
      n++;
    end while (!k && n < 50);
  endtask

  task automatic rand_read(input logic [8:0] a, output logic [7:0] d);
    logic k;
    i2c_start();
    send_byte(ctrl(a, 1'b0), k);
    send_byte(a[7:0], k);
    i2c_start();
    send_byte(ctrl(a, 1'b1), k);
    recv_byte(d, 1'b0);
    i2c_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic k;
    i2c_start();
    send_byte(8'hA1, k);
    recv_byte(d, 1'b0);
    i2c_stop();
  endtask

  initial begin
    #750000;
    total++; fails++;
    $display("FAIL R11 watchdog: got hung run expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic ok, k;
    logic [7:0] d, d1, d2;
    int n;
    realtime t0, t1;

    repeat (4) @(posedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 sda released after reset", sda_oe, 0);
    poll_ready(n);
    chk("R11 not busy after reset", n, 1);

    // table walk: write each entry, then measure the busy window (R7)
    foreach (VEC[i]) begin
      write_byte(VEC[i][16:8], VEC[i][7:0], ok);
      t0 = $realtime;
      chk("R3 byte write acknowledged", ok, 1);
      poll_ready(n);
      t1 = $realtime;
      chk("R7 poll NACKed right after stop", (n > 1) ? 1 : 0, 1);
      chk("R7 busy lasts at least WRITE_CYCLES",
          ((t1 - t0) >= WCYC * 5.0) ? 1 : 0, 1);
      chk("R7 ready soon after write cycle",
          ((t1 - t0) <= WCYC * 5.0 + 4000.0) ? 1 : 0, 1);
    end
    foreach (VEC[i]) begin
      rand_read(VEC[i][16:8], d);
      chk("R2 R5 random read-back", d, VEC[i][7:0]);
    end

    // R4: current read after a random read of 0x010
    rand_read(9'h010, d);
    cur_read(d1);
    chk("R4 current address read", d1, 8'h22);

    // R6: sequential read across the wrap point
    i2c_start();
    send_byte(ctrl(9'h1FF, 1'b0), k);
    send_byte(8'hFF, k);
    i2c_start();
    send_byte(ctrl(9'h1FF, 1'b1), k);
    recv_byte(d, 1'b1);
    recv_byte(d1, 1'b1);
    recv_byte(d2, 1'b0);
    i2c_stop();
    chk("R6 sequential byte 0", d, 8'hA5);
    chk("R6 wrap to address 0", d1, 8'h5A);
    chk("R6 sequential byte 2", d2, 8'h3C);

    // R3: second data byte is refused and discarded
    i2c_start();
    send_byte(8'hA0, k);
    send_byte(8'h30, k);
    send_byte(8'h77, k);
    chk("R3 first data byte ACK", k, 1);
    send_byte(8'h88, k);
    chk("R3 second data byte NACK", k, 0);
    i2c_stop();
    poll_ready(n);
    rand_read(9'h030, d);
    chk("R3 only first byte stored", d, 8'h77);

    // R8: write-protected write
    wp = 1'b1;
    write_byte(9'h010, 8'h99, ok);
    chk("R8 protected write still acknowledged", ok, 1);
    poll_ready(n);
    wp = 1'b0;
    chk("R8 no busy period", n, 1);
    rand_read(9'h010, d);
    chk("R8 memory unchanged", d, 8'h11);

    // R9: low-supply inhibit
    lowv = 1'b1;
    write_byte(9'h011, 8'h66, ok);
    poll_ready(n);
    lowv = 1'b0;
    chk("R9 no busy period", n, 1);
    rand_read(9'h011, d);
    chk("R9 memory unchanged", d, 8'h22);

    // R1: foreign device code
    i2c_start();
    send_byte(8'hB0, k);
    chk("R1 wrong code NACKed", k, 0);
    send_byte(8'h00, k);
    chk("R1 slave stays silent", k, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'hA0, k);
    i2c_stop();
    chk("R1 own code ACKed", k, 1);

    chk("R10 enable moved only with SCL low", oe_viol, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule